// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Post-Divider

This block turns a fast source clock into a slower one. The ratio is picked at run time with a 3-bit select word. That word indexes a table of eight ratios fixed at elaboration. Every entry must come from the set 1, 2, 3, 4, 6, 8, 9, 10, 12 and 15. The source clock itself is never altered: only the division applied to it changes.

The select word may change at any time and with no relation to the source clock. The block first synchronizes it. It then lets the cycle already running under the old ratio finish, adds a short quiet gap, and starts the new ratio with a whole cycle. The output may stay low for longer than usual while this happens. It never shows a high or low phase shorter than half of the smaller of the two periods involved.

Odd ratios keep an exact 50% duty cycle. A copy of the output taken on the falling source edge stretches the high phase by half a source period. Ratio 1 forwards the source clock through a gate that is enabled on the falling edge.

Top module: `fsel_clk_divider`

## Requirements
- R1: In steady state the output period equals the selected ratio times the source period, for every ratio the table may hold (1, 2, 3, 4, 6, 8, 9, 10, 12, 15).
- R2: freqSel is an index into the ratio table. With the default table the mapping is index 0→4, 1→1, 2→3, 3→2, 4→9, 5→6, 6→15 and 7→10.
- R3: freqSel passes through a two-flop synchronizer. A value is acted on only once it reads the same on two consecutive source cycles after synchronization, so a select excursion that lasts one source cycle leaves the output unchanged.
- R4: While the ratio changes, no output high or low phase is shorter than half of the smaller of the old and new output periods.
- R5: A ratio change takes effect only at the end of a low phase of the old ratio. Every high phase the output produces is a complete high phase of either the old or the new ratio.
- R6: In steady state the high phase lasts exactly half the output period, N half source periods for ratio N, and this holds for odd N as well.
- R7: At ratio 1 the output is the gated source clock, high for half a source period in every source cycle.
- R8: While rstN is low the output is low. The first high phase after rstN is released is complete for the ratio the select word indexes.
- R9: The first high phase of a new ratio starts no more than N_old + 5 source cycles after the select word changes, where N_old is the ratio in use before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source clock that is divided |
| rstN | input | 1 | Asynchronous active-low reset |
| freqSel | input | 3 | Ratio-table index; may change asynchronously to srcClk |
| clkOut | output | 1 | Divided clock |

## Verification
The assertions assume a free-running srcClk. They also assume that a new freqSel value is held long enough to reach the synchronizer output on two consecutive cycles before it can be acted on. Outside the one deliberate single-cycle excursion, the stimulus changes freqSel only on falling source edges and holds each value for tens of source cycles, so every change is settled before the next one starts. Changes are applied at varying phases of the output cycle, so the switch logic meets the old ratio at different counter positions. The bench timestamps every output edge and measures each high and low phase against the old and new ratios.

// File: rtl/fsdiv_pkg.sv
`timescale 1ns/1ps
package fsdiv_pkg;
  // width of one ratio entry; the largest legal ratio is 15
  localparam int RatioW = 4;

  typedef logic [RatioW-1:0] ratio_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;   // take a new ratio, go quiet
    logic   start;  // begin the first full cycle of the loaded ratio
    ratio_t ratio;  // ratio carried with load
  } divStrobe_t;

  function automatic logic isLegalRatio(ratio_t r);
    case (r)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd9, 4'd10, 4'd12, 4'd15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fsel_div_ctrl.sv
`timescale 1ns/1ps
module fsel_div_ctrl
  import fsdiv_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int SYNC_DEPTH = 2,
  parameter logic [(2**SEL_W)*RatioW-1:0] RATIO_TABLE = '0
) (
  input  logic             srcClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selIn,
  input  logic             wrap,
  output divStrobe_t       strobe
);
  // one stage beyond the synchronizer holds the previous settled value
  localparam int PipeLen = SYNC_DEPTH + 1;
  localparam int WarmW   = $clog2(PipeLen + 1);

  typedef enum logic [1:0] {S_WARM, S_HOLD, S_RUN} ctrlState_t;

  logic [PipeLen-1:0][SEL_W-1:0] selPipe;
  logic [SEL_W-1:0]              selNow, selPrev, curSel;
  logic [WarmW-1:0]              warmCnt;
  logic                          warmDone, selSettled, doLoad;
  ctrlState_t                    state;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) selPipe <= '0;
    else       selPipe <= {selPipe[PipeLen-2:0], selIn};
  end

  assign selNow  = selPipe[SYNC_DEPTH-1];
  assign selPrev = selPipe[SYNC_DEPTH];

  // pipe contents are meaningful only after it has refilled since reset
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN)          warmCnt <= '0;
    else if (!warmDone) warmCnt <= warmCnt + WarmW'(1);
  end
  assign warmDone   = (warmCnt == WarmW'(PipeLen));
  assign selSettled = warmDone && (selNow == selPrev);

  always_comb begin
    doLoad = 1'b0;
    if (selSettled) begin
      if (state == S_WARM)                                   doLoad = 1'b1;
      else if (state == S_RUN && wrap && selNow != curSel)  doLoad = 1'b1;
    end
  end

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_WARM;
      curSel <= '0;
    end else begin
      if (doLoad) curSel <= selNow;
      case (state)
        S_WARM:  if (doLoad) state <= S_HOLD;
        S_HOLD:  state <= S_RUN;
        S_RUN:   if (doLoad) state <= S_HOLD;
        default: state <= S_WARM;
      endcase
    end
  end

  always_comb begin
    strobe.load  = doLoad;
    strobe.start = (state == S_HOLD);
    strobe.ratio = RATIO_TABLE[int'(selNow)*RatioW +: RatioW];
  end

  // R3: the index taken over was the same on both compared stages
  a_r3_sel_settled: assert property (@(posedge srcClk) disable iff (!rstN)
    !$stable(curSel) |-> ($past(selNow) == $past(selPrev)));

  // R3: after a quiet gap the new ratio always starts
  a_r3_hold_one_cycle: assert property (@(posedge srcClk) disable iff (!rstN)
    (state == S_HOLD) |=> (state == S_RUN));
endmodule

// File: rtl/fsel_div_datapath.sv
`timescale 1ns/1ps
module fsel_div_datapath
  import fsdiv_pkg::*;
(
  input  logic       srcClk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  output logic       wrap,
  output logic       clkOut
);
  ratio_t ratio, cnt, nRatio, nCnt;
  logic   running, nRun;
  logic   qPos, oddEn, div1En;   // rising-edge state
  logic   qNeg, passEn;          // falling-edge state

  assign wrap = running && (cnt == ratio - ratio_t'(1));

  always_comb begin
    nRatio = ratio;
    nCnt   = cnt;
    nRun   = running;
    if (strobe.load) begin
      nRatio = strobe.ratio;
      nCnt   = '0;
      nRun   = 1'b0;
    end else if (strobe.start) begin
      nCnt = '0;
      nRun = 1'b1;
    end else if (running) begin
      nCnt = wrap ? '0 : cnt + ratio_t'(1);
    end
  end

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      ratio   <= ratio_t'(2);
      cnt     <= '0;
      running <= 1'b0;
      qPos    <= 1'b0;
      oddEn   <= 1'b0;
      div1En  <= 1'b0;
    end else begin
      ratio   <= nRatio;
      cnt     <= nCnt;
      running <= nRun;
      // high for floor(N/2) rising-edge cycles; odd N adds half a cycle below
      qPos    <= nRun && (nRatio != ratio_t'(1)) && (nCnt < (nRatio >> 1));
      oddEn   <= nRun && nRatio[0] && (nRatio != ratio_t'(1));
      div1En  <= nRun && (nRatio == ratio_t'(1));
    end
  end

  // falling-edge copies: stretch odd high phases, open the ratio-1 gate while srcClk is low
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) begin
      qNeg   <= 1'b0;
      passEn <= 1'b0;
    end else begin
      qNeg   <= qPos && oddEn;
      passEn <= div1En;
    end
  end

  assign clkOut = (srcClk & passEn) | qPos | qNeg;

  // R5: a new ratio is taken only when idle or at the end of a low phase
  a_r5_load_at_wrap: assert property (@(posedge srcClk) disable iff (!rstN)
    strobe.load |-> (!running || wrap));

  // R4: the divided path is low when the ratio is swapped
  a_r4_low_at_load: assert property (@(posedge srcClk) disable iff (!rstN)
    strobe.load |-> (!qPos && !qNeg));

  // R4: a load is followed by exactly one quiet cycle, then a start
  a_r4_quiet_then_start: assert property (@(posedge srcClk) disable iff (!rstN)
    strobe.load |=> strobe.start);

  // R7: the pass-through gate never overlaps the divided path
  a_r7_pass_exclusive: assert property (@(posedge srcClk) disable iff (!rstN)
    passEn |-> (!qPos && !qNeg));

  // R1: counter stays inside the active ratio, which is legal
  a_r1_cnt_range: assert property (@(posedge srcClk) disable iff (!rstN)
    running |-> ((cnt < ratio) && isLegalRatio(ratio)));

  // R1: the ratio is steady between loads
  a_r1_ratio_steady: assert property (@(posedge srcClk) disable iff (!rstN)
    (running && !strobe.load) |=> $stable(ratio));
endmodule

// File: rtl/fsel_clk_divider.sv
`timescale 1ns/1ps
module fsel_clk_divider
  import fsdiv_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int SYNC_DEPTH = 2,
  // entry i sits at bits [i*RatioW +: RatioW]
  parameter logic [(2**SEL_W)*RatioW-1:0] RATIO_TABLE =
    {4'd10, 4'd15, 4'd6, 4'd9, 4'd2, 4'd3, 4'd1, 4'd4}
) (
  input  logic             srcClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] freqSel,
  output logic             clkOut
);
  divStrobe_t strobe;
  logic       wrap;

  fsel_div_ctrl #(
    .SEL_W      (SEL_W),
    .SYNC_DEPTH (SYNC_DEPTH),
    .RATIO_TABLE(RATIO_TABLE)
  ) ctrl_i (
    .srcClk (srcClk),
    .rstN   (rstN),
    .selIn  (freqSel),
    .wrap   (wrap),
    .strobe (strobe)
  );

  fsel_div_datapath dp_i (
    .srcClk (srcClk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrap   (wrap),
    .clkOut (clkOut)
  );
endmodule

// File: tb/fsel_clk_divider_tb_top.sv
`timescale 1ns/1ps
module fsel_clk_divider_tb_top;
  logic       srcClk  = 1'b0;
  logic       rstN    = 1'b0;
  logic [2:0] freqSel = 3'd0;
  logic       clkOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench copy of the default table (R2)
  int ratioTab [8] = '{4, 1, 3, 2, 9, 6, 15, 10};
  int curN = 4;

  always #5 srcClk = ~srcClk;   // 100 MHz

  fsel_clk_divider dut_i (
    .srcClk (srcClk),
    .rstN   (rstN),
    .freqSel(freqSel),
    .clkOut (clkOut)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // edge monitor: widths in half source periods (5 ns units)
  bit  monArmed = 1'b0;
  bit  seenEdge = 1'b0;
  time lastEdge = 0;
  int  halves, minExp;
  int  expA = 4, expB = 4;
  int  runtCount = 0, widthErr = 0;

  always @(clkOut) begin
    if (monArmed) begin
      if (seenEdge) begin
        halves = int'(($time - lastEdge) / 5);
        minExp = (expA < expB) ? expA : expB;
        if (halves < minExp) runtCount++;
        if (!clkOut && halves != expA && halves != expB) widthErr++;
      end
      seenEdge = 1'b1;
      lastEdge = $time;
    end
  end

  task automatic armMonitor(int n);
    expA = n; expB = n; runtCount = 0; widthErr = 0;
    seenEdge = 1'b0; monArmed = 1'b1;
  endtask

  task automatic measurePeriod(output int perH, output int hiH);
    time t0, t1, t2;
    @(posedge clkOut); t0 = $time;
    @(negedge clkOut); t1 = $time;
    @(posedge clkOut); t2 = $time;
    perH = int'((t2 - t0) / 5);
    hiH  = int'((t1 - t0) / 5);
  endtask

  // R8: quiet during reset, full first high phase after release
  task automatic t_reset(int s);
    time t0, t1;
    int hiH;
    monArmed = 1'b0;
    @(negedge srcClk);
    rstN = 1'b0;
    freqSel = 3'(s);
    #1 check(clkOut == 1'b0, "R8", "output just after reset asserted", clkOut, 0);
    repeat (5) @(negedge srcClk);
    check(clkOut == 1'b0, "R8", "output while reset held", clkOut, 0);
    rstN = 1'b1;
    @(posedge clkOut); t0 = $time;
    @(negedge clkOut); t1 = $time;
    hiH = int'((t1 - t0) / 5);
    check(hiH == ratioTab[s], "R8", "first high phase width (half periods)", hiH, ratioTab[s]);
    curN = ratioTab[s];
    armMonitor(curN);
  endtask

  // R1, R2, R6, R7: every table entry in steady state
  task automatic t_each_ratio();
    int perH, hiH, n;
    for (int s = 0; s < 8; s++) begin
      n = ratioTab[s];
      expA = curN; expB = n;
      @(negedge srcClk) freqSel = 3'(s);
      repeat (40) @(negedge srcClk);
      expA = n;
      measurePeriod(perH, hiH);
      check(perH == 2 * n, "R1", $sformatf("period for ratio %0d (half periods)", n), perH, 2 * n);
      check(perH == 2 * ratioTab[s], "R2", $sformatf("period at index %0d", s), perH, 2 * ratioTab[s]);
      check(hiH == n, (n == 1) ? "R7" : "R6", $sformatf("high width for ratio %0d", n), hiH, n);
      curN = n;
    end
    check(runtCount == 0, "R4", "short phases across table sweep", runtCount, 0);
    check(widthErr == 0, "R5", "truncated highs across table sweep", widthErr, 0);
  endtask

  // R3: a one-cycle select excursion is ignored
  task automatic t_sel_blip();
    int perH, hiH;
    expA = curN; expB = 4;
    @(negedge srcClk) freqSel = 3'd0;
    repeat (40) @(negedge srcClk);
    curN = 4;
    armMonitor(4);
    @(negedge srcClk) freqSel = 3'd6;
    @(negedge srcClk) freqSel = 3'd0;
    for (int k = 0; k < 3; k++) begin
      measurePeriod(perH, hiH);
      check(perH == 8 && hiH == 4, "R3", "period after one-cycle select blip", perH, 8);
    end
    check(widthErr == 0, "R3", "foreign widths after select blip", widthErr, 0);
  endtask

  // R9: bounded time to first new high phase, from the longest ratio
  task automatic t_latency();
    time ts, tr, tf;
    bit  found = 1'b0;
    expA = curN; expB = 15;
    @(negedge srcClk) freqSel = 3'd6;
    repeat (40) @(negedge srcClk);
    curN = 15;
    armMonitor(15);
    expB = 2;
    repeat (7) @(negedge srcClk);
    freqSel = 3'd3;
    ts = $time;
    tr = ts;
    for (int k = 0; k < 6 && !found; k++) begin
      @(posedge clkOut); tr = $time;
      @(negedge clkOut); tf = $time;
      if (int'((tf - tr) / 5) == 2) found = 1'b1;
    end
    check(found, "R9", "new ratio observed", found, 1);
    check((tr - ts) <= 200, "R9", "ns from select change to first new high", tr - ts, 200);
    check(runtCount == 0, "R4", "short phases 15 to 2", runtCount, 0);
    curN = 2;
  endtask

  // R4, R5: chain of switches at varying phases
  task automatic t_switch_chain();
    int seq [10] = '{1, 6, 2, 7, 0, 1, 3, 4, 5, 2};
    int perH, hiH, n;
    for (int i = 0; i < 10; i++) begin
      n = ratioTab[seq[i]];
      armMonitor(curN);
      expB = n;
      repeat ((i * 3) % 7 + 1) @(negedge srcClk);
      freqSel = 3'(seq[i]);
      repeat (45) @(negedge srcClk);
      check(runtCount == 0, "R4", $sformatf("short phases switching %0d to %0d", curN, n), runtCount, 0);
      check(widthErr == 0, "R5", $sformatf("truncated highs switching %0d to %0d", curN, n), widthErr, 0);
      measurePeriod(perH, hiH);
      check(perH == 2 * n, "R1", $sformatf("period after switch to %0d", n), perH, 2 * n);
      curN = n;
    end
  endtask

  initial begin
    t_reset(4);
    t_each_ratio();
    t_sel_blip();
    t_latency();
    t_switch_chain();
    t_reset(1);
    t_reset(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      check(1'b0, "watchdog", "run did not finish, cycles", 100000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule